// File: doc/BRIEF.md
# Double-to-Integer Conversion Unit

This unit turns one IEEE-754 binary64 operand into a signed two's-complement integer. A width select picks the result size: a 32-bit result (placed in bits 31:0, with the upper half zero) or a full 64-bit result. Fractions are rounded in one of four modes. By default the mode comes from a global rounding field. A per-operation static rounding field replaces it when its enable is set and the operand comes from a register.

A value that cannot be represented does not saturate. This covers a rounded magnitude outside the selected range, a NaN and an infinity. In each case the unit raises the invalid flag and returns the fixed "integer indefinite" pattern for the selected width, which is the sign bit alone. A conversion that drops nonzero fraction bits, and is otherwise valid, raises the inexact flag. These two flags are the only exception conditions the unit reports.

The unit has one pipeline stage. Operands are sampled every cycle, and the result and flags appear on registered outputs one clock later.

Top module: `dbl2int_cvt`

## Requirements
- R1: The result and both flags are registered. They are all zero while reset is held. The conversion of the operand present at a rising edge appears on the outputs right after that edge.
- R2: The rounding-mode encoding is 00 = nearest with ties to even, 01 = toward negative infinity, 10 = toward positive infinity, 11 = toward zero.
- R3: When both `rc_static_en_i` and `src_is_reg_i` are 1, `rc_static_i` is the mode used. In every other case `rc_global_i` is used.
- R4: When `wide_i` = 0, the signed result is in bits 31:0 and bits 63:32 are zero. When `wide_i` = 1, all 64 bits hold the signed result.
- R5: In 32-bit mode, a rounded value outside [-2^31, 2^31-1] sets invalid and returns 0x0000_0000_8000_0000.
- R6: In 64-bit mode, a rounded value outside [-2^63, 2^63-1] sets invalid and returns 0x8000_0000_0000_0000.
- R7: A NaN or infinity operand (exponent field all ones) sets invalid, clears inexact, and returns the indefinite value for the selected width.
- R8: Inexact is set exactly when nonzero fraction bits are discarded and the result is valid. It is never set together with invalid.
- R9: Exactly -2^31 in 32-bit mode and exactly -2^63 in 64-bit mode are valid results and do not set invalid.
- R10: The range check is applied to the rounded value. For example, 2147483647.4 in nearest mode gives 0x7FFFFFFF, while 2147483647.5 in nearest mode is out of range.
- R11: A denormal operand converts to 0, -1 or +1 as its sign and the rounding mode dictate, and sets inexact.
- R12: An integral operand, including either signed zero, converts exactly with both flags clear. Negative results are in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | binary64 source operand |
| wide_i | input | 1 | 1 = 64-bit result, 0 = 32-bit result |
| rc_global_i | input | 2 | Global rounding mode |
| rc_static_i | input | 2 | Per-operation static rounding mode |
| rc_static_en_i | input | 1 | Enables the static rounding override |
| src_is_reg_i | input | 1 | Operand comes from a register |
| res_o | output | 64 | Integer result |
| invalid_o | output | 1 | Invalid-operation flag |
| inexact_o | output | 1 | Precision (inexact) flag |

## Verification
Every result and both flags depend only on the operand and controls captured at the previous rising edge. Each is due exactly one cycle after the stimulus is applied. The bench drives a new operand on a falling edge and reads all three outputs on the next falling edge, half a period after the capturing edge. In the checker, properties use a single-cycle implication from the inputs to the outputs.

// File: rtl/dbl2int_cvt.sv
module dbl2int_cvt #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int BIAS   = 1023
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] src_i,
  input  logic        wide_i,
  input  logic [1:0]  rc_global_i,
  input  logic [1:0]  rc_static_i,
  input  logic        rc_static_en_i,
  input  logic        src_is_reg_i,
  output logic [63:0] res_o,
  output logic        invalid_o,
  output logic        inexact_o
);
  localparam int MANT_W = FRAC_W + 1;
  localparam int EXACT_E = BIAS + FRAC_W;
  localparam int BIG_E = BIAS + 63;
  localparam int TINY_E = EXACT_E - 64;
  localparam int FIX_W = MANT_W + 64;

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic [MANT_W-1:0] mant;
  logic [1:0]        mode;

  assign sgn  = src_i[63];
  assign ex   = src_i[62:52];
  assign fr   = src_i[51:0];
  assign mant = {|ex, fr};
  assign mode = (rc_static_en_i && src_is_reg_i) ? rc_static_i : rc_global_i;

  logic             special, big, grd, stk;
  logic [63:0]      mag;
  logic [FIX_W-1:0] fixed;
  logic [EXP_W-1:0] rsh, lsh;

  assign rsh   = EXP_W'(EXACT_E) - ex;
  assign lsh   = ex - EXP_W'(EXACT_E);
  assign fixed = {mant, 64'b0} >> rsh;

  always_comb begin
    special = &ex;
    big     = 1'b0;
    mag     = '0;
    grd     = 1'b0;
    stk     = 1'b0;
    if (special) begin
      big = 1'b0;
    end else if (ex > EXP_W'(BIG_E)) begin
      big = 1'b1;
    end else if (ex >= EXP_W'(EXACT_E)) begin
      mag = {11'b0, mant} << lsh[3:0];
    end else if (ex >= EXP_W'(TINY_E)) begin
      mag = {11'b0, fixed[FIX_W-1:64]};
      grd = fixed[63];
      stk = |fixed[62:0];
    end else begin
      stk = |src_i[62:0];
    end
  end

  logic inc;
  always_comb begin
    case (mode)
      2'b00:   inc = grd & (stk | mag[0]);
      2'b01:   inc = sgn & (grd | stk);
      2'b10:   inc = ~sgn & (grd | stk);
      default: inc = 1'b0;
    endcase
  end

  logic [64:0] rnd;
  logic [64:0] lim;
  logic        ovf, inv_d, inx_d;
  logic [63:0] val, res_d;

  assign rnd = {1'b0, mag} + {64'b0, inc};
  assign lim = wide_i ? ({1'b0, 64'h8000_0000_0000_0000} - {64'b0, ~sgn})
                      : ({33'b0, 32'h8000_0000} - {64'b0, ~sgn});
  assign ovf   = rnd > lim;
  assign inv_d = special | big | ovf;
  assign inx_d = ~inv_d & (grd | stk);
  assign val   = sgn ? (~rnd[63:0] + 64'd1) : rnd[63:0];

  always_comb begin
    if (inv_d)
      res_d = wide_i ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
    else
      res_d = wide_i ? val : {32'b0, val[31:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_o     <= '0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
    end else begin
      res_o     <= res_d;
      invalid_o <= inv_d;
      inexact_o <= inx_d;
    end
  end
endmodule

// File: rtl/dbl2int_cvt_chk.sv
module dbl2int_cvt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] src_i,
  input logic        wide_i,
  input logic [63:0] res_o,
  input logic        invalid_o,
  input logic        inexact_o
);
  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> !inexact_o);

  assert_nan_inf_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (&src_i[62:52]) |=> (invalid_o && !inexact_o));

  assert_indefinite_wide_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((&src_i[62:52]) && wide_i) |=> (res_o == 64'h8000_0000_0000_0000));

  assert_narrow_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_i |=> (res_o[63:32] == 32'b0));

  assert_zero_exact_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i[62:0] == 63'b0) |=> (res_o == 64'b0 && !invalid_o && !inexact_o));
endmodule

bind dbl2int_cvt dbl2int_cvt_chk chk_i (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .wide_i(wide_i),
  .res_o(res_o), .invalid_o(invalid_o), .inexact_o(inexact_o)
);

// File: tb/dbl2int_cvt_tb_top.sv
module dbl2int_cvt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_i = '0;
  logic        wide_i = 1'b0;
  logic [1:0]  rc_global_i = 2'b00;
  logic [1:0]  rc_static_i = 2'b00;
  logic        rc_static_en_i = 1'b0;
  logic        src_is_reg_i = 1'b0;
  logic [63:0] res_o;
  logic        invalid_o, inexact_o;

  int checks = 0;
  int errors = 0;

  localparam logic [63:0] IND64 = 64'h8000_0000_0000_0000;
  localparam logic [63:0] IND32 = 64'h0000_0000_8000_0000;

  always #4 clk = ~clk;

  dbl2int_cvt dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wide_i(wide_i),
    .rc_global_i(rc_global_i), .rc_static_i(rc_static_i),
    .rc_static_en_i(rc_static_en_i), .src_is_reg_i(src_is_reg_i),
    .res_o(res_o), .invalid_o(invalid_o), .inexact_o(inexact_o)
  );

  task automatic expect_out(string req, logic [63:0] er, logic ei, logic ex);
    checks++;
    if (res_o !== er || invalid_o !== ei || inexact_o !== ex) begin
      errors++;
      $display("FAIL %s: got res=%h inv=%b inx=%b, expected res=%h inv=%b inx=%b",
               req, res_o, invalid_o, inexact_o, er, ei, ex);
    end
  endtask

  task automatic conv(string req, logic [63:0] s, logic w, logic [1:0] rg,
                      logic [63:0] er, logic ei, logic ex);
    @(negedge clk);
    src_i = s; wide_i = w; rc_global_i = rg;
    rc_static_en_i = 1'b0; src_is_reg_i = 1'b0;
    @(negedge clk);
    expect_out(req, er, ei, ex);
  endtask

  task automatic t_reset;
    @(negedge clk);
    expect_out("R1 reset", 64'b0, 1'b0, 1'b0);
    src_i = $realtobits(5.0);
    @(negedge clk);
    expect_out("R1 held in reset", 64'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 first result", 64'd5, 1'b0, 1'b0);
  endtask

  task automatic t_modes;
    conv("R2 rne 2.5", $realtobits(2.5), 1'b0, 2'b00, 64'd2, 1'b0, 1'b1);
    conv("R2 rne 3.5", $realtobits(3.5), 1'b0, 2'b00, 64'd4, 1'b0, 1'b1);
    conv("R2 rne 1.5", $realtobits(1.5), 1'b0, 2'b00, 64'd2, 1'b0, 1'b1);
    conv("R2 rne 0.5", $realtobits(0.5), 1'b0, 2'b00, 64'd0, 1'b0, 1'b1);
    conv("R2 rne -2.5", $realtobits(-2.5), 1'b0, 2'b00, 64'h0000_0000_FFFF_FFFE, 1'b0, 1'b1);
    conv("R2 dn -2.5", $realtobits(-2.5), 1'b0, 2'b01, 64'h0000_0000_FFFF_FFFD, 1'b0, 1'b1);
    conv("R2 up -2.5", $realtobits(-2.5), 1'b0, 2'b10, 64'h0000_0000_FFFF_FFFE, 1'b0, 1'b1);
    conv("R2 tz -2.5", $realtobits(-2.5), 1'b0, 2'b11, 64'h0000_0000_FFFF_FFFE, 1'b0, 1'b1);
    conv("R2 up 2.5", $realtobits(2.5), 1'b0, 2'b10, 64'd3, 1'b0, 1'b1);
    conv("R2 up 0.3", $realtobits(0.3), 1'b0, 2'b10, 64'd1, 1'b0, 1'b1);
    conv("R2 dn wide -0.3", $realtobits(-0.3), 1'b1, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1);
  endtask

  task automatic t_static;
    @(negedge clk);
    src_i = $realtobits(2.7); wide_i = 1'b0; rc_global_i = 2'b00;
    rc_static_i = 2'b11; rc_static_en_i = 1'b1; src_is_reg_i = 1'b1;
    @(negedge clk);
    expect_out("R3 static override", 64'd2, 1'b0, 1'b1);
    src_is_reg_i = 1'b0;
    @(negedge clk);
    expect_out("R3 memory source uses global", 64'd3, 1'b0, 1'b1);
    src_is_reg_i = 1'b1; rc_static_en_i = 1'b0;
    @(negedge clk);
    expect_out("R3 disabled uses global", 64'd3, 1'b0, 1'b1);
  endtask

  task automatic t_range;
    conv("R10 2147483647.4", $realtobits(2147483647.4), 1'b0, 2'b00, 64'h7FFF_FFFF, 1'b0, 1'b1);
    conv("R10 2147483647.5", $realtobits(2147483647.5), 1'b0, 2'b00, IND32, 1'b1, 1'b0);
    conv("R10 2147483647.5 tz", $realtobits(2147483647.5), 1'b0, 2'b11, 64'h7FFF_FFFF, 1'b0, 1'b1);
    conv("R5 1e10 narrow", $realtobits(1.0e10), 1'b0, 2'b00, IND32, 1'b1, 1'b0);
    conv("R5 -2147483649", $realtobits(-2147483649.0), 1'b0, 2'b00, IND32, 1'b1, 1'b0);
    conv("R4 1e10 wide", $realtobits(1.0e10), 1'b1, 2'b00, 64'd10000000000, 1'b0, 1'b0);
    conv("R6 2^63", $realtobits(9223372036854775808.0), 1'b1, 2'b00, IND64, 1'b1, 1'b0);
    conv("R6 -2^64", $realtobits(-18446744073709551616.0), 1'b1, 2'b00, IND64, 1'b1, 1'b0);
    conv("R6 1e300", $realtobits(1.0e300), 1'b1, 2'b00, IND64, 1'b1, 1'b0);
    conv("R4 2^62 wide", $realtobits(4611686018427387904.0), 1'b1, 2'b00, 64'h4000_0000_0000_0000, 1'b0, 1'b0);
  endtask

  task automatic t_minneg;
    conv("R9 -2^31", $realtobits(-2147483648.0), 1'b0, 2'b00, IND32, 1'b0, 1'b0);
    conv("R9 -2^31-0.5 tz", $realtobits(-2147483648.5), 1'b0, 2'b11, IND32, 1'b0, 1'b1);
    conv("R9 -2^31-0.5 rne", $realtobits(-2147483648.5), 1'b0, 2'b00, IND32, 1'b0, 1'b1);
    conv("R10 -2^31-0.5 dn", $realtobits(-2147483648.5), 1'b0, 2'b01, IND32, 1'b1, 1'b0);
    conv("R9 -2^63", $realtobits(-9223372036854775808.0), 1'b1, 2'b00, IND64, 1'b0, 1'b0);
  endtask

  task automatic t_special;
    conv("R7 qnan wide", 64'h7FF8_0000_0000_0000, 1'b1, 2'b00, IND64, 1'b1, 1'b0);
    conv("R7 +inf narrow", 64'h7FF0_0000_0000_0000, 1'b0, 2'b00, IND32, 1'b1, 1'b0);
    conv("R7 -inf wide", 64'hFFF0_0000_0000_0000, 1'b1, 2'b11, IND64, 1'b1, 1'b0);
    conv("R7 snan narrow", 64'h7FF0_0000_0000_0001, 1'b0, 2'b10, IND32, 1'b1, 1'b0);
  endtask

  task automatic t_denorm;
    conv("R11 denorm rne", 64'h0000_0000_0000_0001, 1'b0, 2'b00, 64'd0, 1'b0, 1'b1);
    conv("R11 denorm up", 64'h0000_0000_0000_0001, 1'b0, 2'b10, 64'd1, 1'b0, 1'b1);
    conv("R11 -denorm dn", 64'h8000_0000_0000_0001, 1'b0, 2'b01, 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b1);
    conv("R11 -denorm up", 64'h8000_0000_0000_0001, 1'b1, 2'b10, 64'd0, 1'b0, 1'b1);
    conv("R8 tiny normal up", $realtobits(1.0e-300), 1'b1, 2'b10, 64'd1, 1'b0, 1'b1);
  endtask

  task automatic t_exact;
    conv("R12 123", $realtobits(123.0), 1'b0, 2'b00, 64'd123, 1'b0, 1'b0);
    conv("R12 -7 wide", $realtobits(-7.0), 1'b1, 2'b01, 64'hFFFF_FFFF_FFFF_FFF9, 1'b0, 1'b0);
    conv("R4 -7 narrow", $realtobits(-7.0), 1'b0, 2'b01, 64'h0000_0000_FFFF_FFF9, 1'b0, 1'b0);
    conv("R12 +0", 64'h0, 1'b1, 2'b01, 64'd0, 1'b0, 1'b0);
    conv("R12 -0", 64'h8000_0000_0000_0000, 1'b1, 2'b10, 64'd0, 1'b0, 1'b0);
    conv("R8 exact 2^52+1", $realtobits(4503599627370497.0), 1'b1, 2'b00, 64'd4503599627370497, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_modes();
    t_static();
    t_range();
    t_minneg();
    t_special();
    t_denorm();
    t_exact();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule